// File: doc/BRIEF.md
# Cascadable Fall-Through Dual-Clock FIFO

This block is an 18-bit dual-clock FIFO whose output stage works in fall-through fashion. A word written into an empty FIFO moves to the data outputs by itself, and a low `or_n` flag announces it. The consumer never has to issue a read just to see the head word. The read enable only takes the current word and brings up the next one.

Both handshake flags are active low and registered or derived so that identical instances can be chained with no glue logic. The data outputs of one instance drive the data inputs of the next. The upstream `or_n` drives the downstream write enable, and the downstream `ir_n` drives the upstream read enable. Data then ripples forward and free space ripples backward with fixed per-stage latencies. In a chain, the clock between two stages serves as the upstream read clock and the downstream write clock. A synchronous master reset clears the pointers and latches the operating mode from `fwft_sel`. Only the fall-through mode moves data. Pointers cross between the clock domains as Gray code through two-flop synchronizers.

Top module: `fcas_fifo`

## Requirements
- R1: While `mrst` is high and in the first cycle after it falls in fall-through mode, `or_n` is 1, `ir_n` is 0 and `dout` is all zeros.
- R2: A word written into an empty FIFO makes `or_n` go low at the third read-clock rising edge after the write edge, with no read request, and the word is then on `dout`.
- R3: Words leave in the order they were accepted, and this holds also when the write and read clocks are unrelated. A write is accepted at a `wclk` edge with `wen_n`=0 and `ir_n`=0. A read is taken at an `rclk` edge with `ren_n`=0 and `or_n`=0.
- R4: With no reads, `ir_n` goes high after exactly 2^ADDR_W+1 accepted words, counting the storage plus the output register. Writes made while `ir_n` is high are dropped and never appear at the output.
- R5: Starting from full, a read makes `ir_n` go low at the second write-clock rising edge after the read edge.
- R6: A read taken from the last stored word makes `or_n` go high at that edge while `dout` keeps the last word. Reads requested while `or_n` is high are ignored, and no later word is skipped.
- R7: While `or_n` is low and `ren_n` is high, `or_n` stays low and `dout` does not change.
- R8: With `oe_n`=1, `dout` is all zeros and the flags are unchanged. With `oe_n`=0, `dout` shows the held word.
- R9: `fwft_sel` is sampled only while `mrst` is high. Value 1 selects fall-through mode. Value 0 parks the block, with `ir_n` and `or_n` held at 1 and writes ignored. Changing `fwft_sel` after reset has no effect.
- R10: In a two-stage chain that starts empty, a word written into the first stage makes the last stage's `or_n` go low at the seventh transfer-clock edge after the write edge.
- R11: A two-stage chain accepts 2*(2^ADDR_W+1) words before the first stage's `ir_n` goes high, and delivers them in order.
- R12: Starting from a full two-stage chain, one read from the last stage makes the first stage's `ir_n` go low at the fifth transfer-clock edge after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, free-running |
| mrst | input | 1 | Master reset, synchronous, active high, held across several edges of both clocks |
| fwft_sel | input | 1 | Mode select, sampled during reset (1 = fall-through) |
| wen_n | input | 1 | Write enable, active low |
| din | input | WIDTH | Write data |
| ir_n | output | 1 | Input ready, low while at least one location is free |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low; high forces `dout` to zero |
| dout | output | WIDTH | Head word of the queue |
| or_n | output | 1 | Output ready, low while a valid word is on `dout` |

## Verification
The hardest state to reach from the ports is a chain that is full in both stages, with the backward free-space ripple then measured. The bench reaches it by stalling the last stage's read enable. It then offers writes to the first stage for as long as its `ir_n` allows, until the first stage has filled too. A reference queue tracks every accepted word at the chain's input and output, and a single read then starts the edge count to the first stage's `ir_n`. Ordering across unrelated clocks is stressed on a separate instance. That instance's read clock runs at a period that does not divide the write period, and both sides are throttled with irregular enable patterns.

// File: rtl/fcas_pkg.sv
package fcas_pkg;

    localparam int WORD_W   = 18;
    localparam int GRAY_MAX = 16;

    typedef enum logic {
        MODE_PARKED = 1'b0,
        MODE_FWFT   = 1'b1
    } op_mode_e;

    function automatic logic [GRAY_MAX-1:0] bin_to_gray(input logic [GRAY_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/fcas_sync2.sv
module fcas_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fcas_mem.sv
module fcas_mem #(
    parameter int WIDTH  = 18,
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] ram [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/fcas_wr_ctrl.sv
module fcas_wr_ctrl
    import fcas_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int PW    = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              mrst,
    input  logic              mode_pin,
    input  logic              wen_n,
    input  logic [PW-1:0]     rgray_s,
    output logic [PW-1:0]     wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              we,
    output logic              ir_n,
    output op_mode_e          mode_w
);
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic          full;

    // full: write pointer one lap ahead of the synchronized read pointer
    assign full     = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign ir_n     = full || (mode_w != MODE_FWFT);
    assign we       = !wen_n && !ir_n;
    assign wbin_nxt = wbin + 1'b1;
    assign waddr    = wbin[ADDR_W-1:0];

    always_ff @(posedge wclk) begin
        if (mrst) begin
            mode_w <= op_mode_e'(mode_pin);
            wbin   <= '0;
            wgray  <= '0;
        end else if (we) begin
            wbin  <= wbin_nxt;
            wgray <= PW'(bin_to_gray(GRAY_MAX'(wbin_nxt)));
        end
    end
endmodule

// File: rtl/fcas_rd_ctrl.sv
module fcas_rd_ctrl
    import fcas_pkg::*;
#(
    parameter int WIDTH  = 18,
    parameter int ADDR_W = 10,
    localparam int PW    = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              mrst,
    input  logic              mode_pin,
    input  logic              ren_n,
    input  logic [PW-1:0]     wgray_s,
    input  logic [WIDTH-1:0]  rdata,
    output logic [PW-1:0]     rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  q_data,
    output logic              or_n,
    output logic              rd_empty,
    output op_mode_e          mode_r
);
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic          out_vld;
    logic          load;

    assign rd_empty = (rgray == wgray_s);
    // fetch into the output register when it is free or being consumed
    assign load     = (mode_r == MODE_FWFT) && !rd_empty && (!out_vld || !ren_n);
    assign rbin_nxt = rbin + 1'b1;
    assign raddr    = rbin[ADDR_W-1:0];
    assign or_n     = !out_vld;

    always_ff @(posedge rclk) begin
        if (mrst) begin
            mode_r  <= op_mode_e'(mode_pin);
            rbin    <= '0;
            rgray   <= '0;
            out_vld <= 1'b0;
            q_data  <= '0;
        end else if (load) begin
            rbin    <= rbin_nxt;
            rgray   <= PW'(bin_to_gray(GRAY_MAX'(rbin_nxt)));
            q_data  <= rdata;
            out_vld <= 1'b1;
        end else if (!ren_n) begin
            out_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/fcas_fifo.sv
module fcas_fifo
    import fcas_pkg::*;
#(
    parameter int WIDTH  = WORD_W,
    parameter int ADDR_W = 10
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst,
    input  logic             fwft_sel,
    input  logic             wen_n,
    input  logic [WIDTH-1:0] din,
    output logic             ir_n,
    input  logic             ren_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             or_n
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              we;
    logic              rd_empty;
    logic [WIDTH-1:0]  rdata, q_data;
    op_mode_e          mode_w, mode_r;

    fcas_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk(wclk), .mrst(mrst), .mode_pin(fwft_sel), .wen_n(wen_n),
        .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .we(we),
        .ir_n(ir_n), .mode_w(mode_w)
    );

    fcas_sync2 #(.W(PW)) u_r2w (
        .clk(wclk), .rst(mrst), .d(rgray), .q(rgray_s)
    );

    fcas_sync2 #(.W(PW)) u_w2r (
        .clk(rclk), .rst(mrst), .d(wgray), .q(wgray_s)
    );

    fcas_mem #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    fcas_rd_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
        .rclk(rclk), .mrst(mrst), .mode_pin(fwft_sel), .ren_n(ren_n),
        .wgray_s(wgray_s), .rdata(rdata), .rgray(rgray), .raddr(raddr),
        .q_data(q_data), .or_n(or_n), .rd_empty(rd_empty), .mode_r(mode_r)
    );

    assign dout = oe_n ? '0 : q_data;
endmodule

// File: rtl/fcas_chk.sv
module fcas_chk #(
    parameter int WIDTH  = 18,
    parameter int ADDR_W = 10,
    localparam int PW    = ADDR_W + 1
) (
    input logic             wclk,
    input logic             rclk,
    input logic             mrst,
    input logic             ren_n,
    input logic             ir_n,
    input logic             or_n,
    input logic             rd_empty,
    input logic [PW-1:0]    wgray,
    input logic [WIDTH-1:0] q_data,
    input logic             mode_w,
    input logic             mode_r
);
    // R4
    no_overflow_chk: assert property (@(posedge wclk) disable iff (mrst)
        ir_n |=> $stable(wgray));

    // R3
    gray_step_chk: assert property (@(posedge wclk) disable iff (mrst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R6
    last_word_chk: assert property (@(posedge rclk) disable iff (mrst)
        (!or_n && !ren_n && rd_empty) |=> or_n);

    // R6
    idle_hold_chk: assert property (@(posedge rclk) disable iff (mrst)
        (or_n && $past(or_n)) |-> $stable(q_data));

    // R7
    word_hold_chk: assert property (@(posedge rclk) disable iff (mrst)
        (!or_n && ren_n) |=> (!or_n && $stable(q_data)));

    // R9
    mode_rd_lock_chk: assert property (@(posedge rclk) disable iff (mrst)
        1'b1 |=> $stable(mode_r));

    // R9
    mode_wr_lock_chk: assert property (@(posedge wclk) disable iff (mrst)
        1'b1 |=> $stable(mode_w));
endmodule

bind fcas_fifo fcas_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .ren_n(ren_n), .ir_n(ir_n),
    .or_n(or_n), .rd_empty(rd_empty), .wgray(wgray), .q_data(q_data),
    .mode_w(mode_w), .mode_r(mode_r)
);

// File: tb/fcas_fifo_tb.sv
`timescale 1ns/1ps
module fcas_fifo_tb;
    localparam int W   = 18;
    localparam int AW  = 4;
    localparam int CAP = (1 << AW) + 1;

    logic clk = 1'b0, rclk2 = 1'b0;
    logic mrst = 1'b1, fwft_sel = 1'b0;
    always #4 clk = ~clk;
    always #5.5 rclk2 = ~rclk2;

    int checks = 0, fails = 0;

    // single-clock instance
    logic d_wen_n = 1, d_ren_n = 1, d_oe_n = 0, d_ir_n, d_or_n;
    logic [W-1:0] d_din = '0, d_dout;
    // unrelated-clock instance
    logic x_wen_n = 1, x_ren_n = 1, x_ir_n, x_or_n;
    logic [W-1:0] x_din = '0, x_dout;
    // two-stage chain
    logic a_wen_n = 1, a_ir_n, ab_or_n, ba_ir_n, b_ren_n = 1, b_or_n, b_ir_n_unused;
    logic [W-1:0] a_din = '0, ab_data, b_dout;

    fcas_fifo #(.WIDTH(W), .ADDR_W(AW)) u_dut (
        .wclk(clk), .rclk(clk), .mrst(mrst), .fwft_sel(fwft_sel), .wen_n(d_wen_n),
        .din(d_din), .ir_n(d_ir_n), .ren_n(d_ren_n), .oe_n(d_oe_n), .dout(d_dout), .or_n(d_or_n));

    fcas_fifo #(.WIDTH(W), .ADDR_W(AW)) u_x (
        .wclk(clk), .rclk(rclk2), .mrst(mrst), .fwft_sel(fwft_sel), .wen_n(x_wen_n),
        .din(x_din), .ir_n(x_ir_n), .ren_n(x_ren_n), .oe_n(1'b0), .dout(x_dout), .or_n(x_or_n));

    fcas_fifo #(.WIDTH(W), .ADDR_W(AW)) u_ca (
        .wclk(clk), .rclk(clk), .mrst(mrst), .fwft_sel(fwft_sel), .wen_n(a_wen_n),
        .din(a_din), .ir_n(a_ir_n), .ren_n(ba_ir_n), .oe_n(1'b0), .dout(ab_data), .or_n(ab_or_n));

    fcas_fifo #(.WIDTH(W), .ADDR_W(AW)) u_cb (
        .wclk(clk), .rclk(clk), .mrst(mrst), .fwft_sel(fwft_sel), .wen_n(ab_or_n),
        .din(ab_data), .ir_n(ba_ir_n), .ren_n(b_ren_n), .oe_n(1'b0), .dout(b_dout), .or_n(b_or_n));

    assign b_ir_n_unused = ba_ir_n;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference queues, compared on every clock (negedge, away from the active edge)
    logic [W-1:0] qd[$], qx[$], qc[$];
    int x_rx = 0;

    always @(negedge clk) begin
        if (mrst) begin
            qd.delete(); qx.delete(); qc.delete();
        end else begin
            if (!d_wen_n && !d_ir_n) qd.push_back(d_din);
            if (!x_wen_n && !x_ir_n) qx.push_back(x_din);
            if (!a_wen_n && !a_ir_n) qc.push_back(a_din);
            if (!d_or_n) chk(qd.size() != 0, "R3 u_dut ready without queued word", 0, 1);
            if (!d_ren_n && !d_or_n && qd.size() != 0) begin
                logic [W-1:0] e;
                e = qd.pop_front();
                chk(d_dout == e, "R3 u_dut order", int'(d_dout), int'(e));
            end
            if (!b_ren_n && !b_or_n) begin
                if (qc.size() == 0) chk(1'b0, "R11 chain output without queued word", 0, 1);
                else begin
                    logic [W-1:0] e;
                    e = qc.pop_front();
                    chk(b_dout == e, "R11 chain order", int'(b_dout), int'(e));
                end
            end
        end
    end

    always @(negedge rclk2) begin
        if (!mrst && !x_ren_n && !x_or_n) begin
            if (qx.size() == 0) chk(1'b0, "R3 u_x output without queued word", 0, 1);
            else begin
                logic [W-1:0] e;
                e = qx.pop_front();
                chk(x_dout == e, "R3 u_x order across clocks", int'(x_dout), int'(e));
                x_rx++;
            end
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic do_reset(input logic m);
        @(posedge clk); #1 mrst = 1'b1; fwft_sel = m;
        repeat (6) @(posedge clk);
        #1 mrst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, cnt;
        logic [W-1:0] held;
        // R9: parked mode
        repeat (6) @(posedge clk);
        #1 mrst = 1'b0;
        chk(d_ir_n == 1 && d_or_n == 1, "R9 parked flags", {d_ir_n, d_or_n}, 2'b11);
        fwft_sel = 1'b1;
        d_din = 18'h00077; d_wen_n = 0;
        repeat (3) tick();
        d_wen_n = 1;
        repeat (6) tick();
        chk(d_or_n == 1, "R9 late mode change ignored or_n", d_or_n, 1);
        chk(d_ir_n == 1, "R9 late mode change ignored ir_n", d_ir_n, 1);

        // R1: reset into fall-through mode, then move the pin (R9)
        do_reset(1'b1);
        chk(d_ir_n == 0, "R1 ir_n after reset", d_ir_n, 0);
        chk(d_or_n == 1, "R1 or_n after reset", d_or_n, 1);
        chk(d_dout == 0, "R1 dout after reset", int'(d_dout), 0);
        fwft_sel = 1'b0;

        // R2: fall-through latency
        d_din = 18'h12345; d_wen_n = 0;
        tick(); d_wen_n = 1;
        n = 0;
        while (d_or_n && n < 12) begin tick(); n++; end
        chk(n == 3, "R2 or_n latency", n, 3);
        chk(d_dout == 18'h12345, "R2 word on dout", int'(d_dout), 18'h12345);

        // R7: hold without read
        repeat (5) tick();
        chk(d_or_n == 0 && d_dout == 18'h12345, "R7 word held", int'(d_dout), 18'h12345);

        // R8: output enable
        d_oe_n = 1; #1;
        chk(d_dout == 0, "R8 dout zero when disabled", int'(d_dout), 0);
        chk(d_or_n == 0 && d_ir_n == 0, "R8 flags unchanged", {d_or_n, d_ir_n}, 0);
        d_oe_n = 0; #1;
        chk(d_dout == 18'h12345, "R8 dout restored", int'(d_dout), 18'h12345);

        // R6: read last word, hold, ignored reads
        d_ren_n = 0; tick(); d_ren_n = 1;
        chk(d_or_n == 1, "R6 or_n high after last read", d_or_n, 1);
        chk(d_dout == 18'h12345, "R6 last word kept", int'(d_dout), 18'h12345);
        d_ren_n = 0; repeat (3) tick(); d_ren_n = 1;
        d_din = 18'h00AAA; d_wen_n = 0; tick(); d_wen_n = 1;
        repeat (6) tick();
        chk(d_or_n == 0 && d_dout == 18'h00AAA, "R6 next word not skipped", int'(d_dout), 18'h00AAA);
        d_ren_n = 0; tick(); d_ren_n = 1;

        // R4: capacity and dropped writes
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            d_din = 18'(18'h100 + i);
            d_wen_n = d_ir_n;
            if (!d_ir_n) cnt++;
            tick();
        end
        d_wen_n = 1;
        chk(cnt == CAP, "R4 accepted words", cnt, CAP);
        chk(d_ir_n == 1, "R4 ir_n high when full", d_ir_n, 1);
        d_din = 18'h3FFFF; d_wen_n = 0; repeat (3) tick(); d_wen_n = 1;

        // R5: free space latency
        d_ren_n = 0; tick(); d_ren_n = 1;
        n = 0;
        while (d_ir_n && n < 12) begin tick(); n++; end
        chk(n == 2, "R5 ir_n latency", n, 2);
        d_ren_n = 0; repeat (30) tick(); d_ren_n = 1;
        chk(qd.size() == 0 && d_or_n == 1, "R4 dropped words absent", qd.size(), 0);

        // R3: unrelated clocks with throttling
        fork
            begin
                int sent = 0, k = 0;
                while (sent < 300) begin
                    x_din = 18'(sent * 37 + 5);
                    if ((k % 3) != 0 && !x_ir_n) begin x_wen_n = 0; sent++; end
                    else x_wen_n = 1;
                    k++;
                    tick();
                end
                x_wen_n = 1;
            end
            begin
                int j = 0;
                while (x_rx < 300 && j < 6000) begin
                    @(posedge rclk2); #1;
                    x_ren_n = ((j % 4) == 1);
                    j++;
                end
                x_ren_n = 1;
            end
        join
        chk(x_rx == 300, "R3 u_x words delivered", x_rx, 300);

        // R10: chain ripple
        a_din = 18'h2BEEF; a_wen_n = 0; tick(); a_wen_n = 1;
        n = 0;
        while (b_or_n && n < 20) begin tick(); n++; end
        chk(n == 7, "R10 chain fall-through latency", n, 7);
        chk(b_dout == 18'h2BEEF, "R10 chain word", int'(b_dout), 18'h2BEEF);
        b_ren_n = 0; tick(); b_ren_n = 1;

        // R11: chain capacity
        cnt = 0;
        for (int i = 0; i < 150; i++) begin
            a_din = 18'(18'h20000 + i * 3);
            a_wen_n = a_ir_n;
            if (!a_ir_n) cnt++;
            tick();
        end
        a_wen_n = 1;
        chk(cnt == 2 * CAP, "R11 chain accepted words", cnt, 2 * CAP);

        // R12: chain bubble
        b_ren_n = 0; tick(); b_ren_n = 1;
        n = 0;
        while (a_ir_n && n < 20) begin tick(); n++; end
        chk(n == 5, "R12 chain free-space latency", n, 5);
        b_ren_n = 0; repeat (80) tick(); b_ren_n = 1;
        held = b_dout;
        chk(qc.size() == 0 && b_or_n == 1, "R11 chain drained", qc.size(), 0);
        chk(held == b_dout, "R6 chain last word kept", int'(b_dout), int'(held));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule